// File: doc/BRIEF.md
# SDRAM Device Command Front-End with Clock-Enable Gating

This block is the command front end on the device side of a four-bank synchronous DRAM with a 32-bit word. It samples the chip select, the three command strobes, the clock enable, the bank select and the multiplexed address on every rising clock edge. It turns the strobes into a decoded command. It latches the row address on a bank activation and the column address on a read or write, each together with the bank number. It keeps an open flag for every bank. The array, the data path, refresh timing and the contents of the mode register belong to other blocks.

Clock-enable gating sits in front of all state. A clock enable sampled low still lets that edge's command through. From the next edge on, every other input is ignored and all state is frozen. If no bank is open once that edge completes, the device reports power-down. Otherwise it reports clock suspend. When the clock enable is sampled high again, the command on that same edge is accepted and both status flags clear.

Downstream logic uses the one-cycle command strobe and the latched bank, row and column fields. It watches the open flags and the error pulse to keep its page bookkeeping consistent.

Top module: `sdram_cmd_frontend`

## Requirements
- R1: After a synchronous reset, all outputs are zero: no strobe, command code 0, cleared bank/row/column fields, all banks closed, no suspend, no power-down and no error.
- R2: Commands decode from {ras_n,cas_n,we_n} while cs_n is low. The encodings are 011 activate (code 1), 101 read (code 2), 100 write (code 3), 010 precharge (code 4), 001 auto refresh (code 5) and 000 mode register set (code 6). An accepted command gives cmd_valid high for exactly one cycle, one cycle after its edge, with cmd_code set.
- R3: An activate latches the bank number and the full address as the row, and sets that bank's bit in bank_open (bit n is bank n).
- R4: A read or write to an open bank latches the bank and the low 8 address bits as the column. It leaves the row field and the open flags unchanged.
- R5: A read or write to a closed bank produces a one-cycle cmd_err pulse with no cmd_valid. The bank, column and open flags stay as they were.
- R6: With cs_n high (deselect), or with {ras_n,cas_n,we_n}=111 (no operation), nothing is strobed and no state changes.
- R7: If cke is sampled low while some bank is still open after that edge, the command on that edge is still executed and cmd_suspend goes high one cycle later. While cke stays low, commands are ignored and the open flags and status hold.
- R8: The edge on which cke is sampled high again accepts its command, and cmd_suspend and cmd_powerdown clear one cycle later.
- R9: A precharge with address bit 10 high closes every bank. With bit 10 low it closes only the addressed bank.
- R10: If cke is sampled low and no bank is open after that edge, cmd_powerdown goes high one cycle later and cmd_suspend stays low. The flags are never both high.
- R11: Auto refresh and mode register set strobe their codes but leave the bank, row and column fields and the open flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| ba | input | 2 | Bank select |
| addr | input | 11 | Multiplexed row/column address |
| cmd_valid | output | 1 | One-cycle strobe for an accepted command |
| cmd_code | output | 3 | Decoded command code |
| cmd_bank | output | 2 | Latched bank |
| cmd_row | output | 11 | Latched row |
| cmd_col | output | 8 | Latched column |
| bank_open | output | 4 | Per-bank open flags |
| cmd_suspend | output | 1 | Clock suspended with a bank open |
| cmd_powerdown | output | 1 | Power-down with all banks idle |
| cmd_err | output | 1 | Read/write to a closed bank |

## Verification
The bench builds the block with its defaults: four banks, an 11-bit address, an 8-bit column and precharge-all on address bit 10. This width lets each bank's open flag be checked on its own, and puts the precharge-all bit in the top address bit, where it can be told apart from column bits. It also allows addresses whose high bits differ from their column bits, which shows that only the low eight bits are latched. Both clock-enable entry cases are reached, one with a bank open and one with all banks idle, along with entry and exit edges that carry real commands.

// File: rtl/sdram_fe_pkg.sv
package sdram_fe_pkg;
  typedef enum logic [2:0] {
    CMD_NONE = 3'd0,
    CMD_ACT  = 3'd1,
    CMD_RD   = 3'd2,
    CMD_WR   = 3'd3,
    CMD_PRE  = 3'd4,
    CMD_REF  = 3'd5,
    CMD_MRS  = 3'd6
  } cmd_e;
endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_fe_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);
  always_comb begin
    cmd = CMD_NONE;
    if (!cs_n) begin
      case ({ras_n, cas_n, we_n})
        3'b011:  cmd = CMD_ACT;
        3'b101:  cmd = CMD_RD;
        3'b100:  cmd = CMD_WR;
        3'b010:  cmd = CMD_PRE;
        3'b001:  cmd = CMD_REF;
        3'b000:  cmd = CMD_MRS;
        default: cmd = CMD_NONE;
      endcase
    end
  end
endmodule

// File: rtl/sdram_cke_gate.sv
module sdram_cke_gate (
  input  logic clk,
  input  logic rst,
  input  logic cke,
  input  logic idle_next,
  output logic accept,
  output logic suspend_q,
  output logic powerdown_q
);
  logic cke_prev;

  // An edge is live if the previous sample was high (entry edge) or this one is (exit edge)
  assign accept = cke_prev | cke;

  always_ff @(posedge clk) begin
    if (rst) begin
      cke_prev    <= 1'b1;
      suspend_q   <= 1'b0;
      powerdown_q <= 1'b0;
    end else begin
      cke_prev <= cke;
      if (cke) begin
        suspend_q   <= 1'b0;
        powerdown_q <= 1'b0;
      end else if (cke_prev) begin
        powerdown_q <= idle_next;
        suspend_q   <= !idle_next;
      end
    end
  end

  p_status_excl_r10: assert property (@(posedge clk) disable iff (rst)
    !(suspend_q && powerdown_q));

  p_hold_low_r7: assert property (@(posedge clk) disable iff (rst)
    (!cke_prev && !cke) |=> ($stable(suspend_q) && $stable(powerdown_q)));

  p_exit_clear_r8: assert property (@(posedge clk) disable iff (rst)
    cke |=> (!suspend_q && !powerdown_q));
endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker
  import sdram_fe_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  localparam int BANK_W = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 accept,
  input  cmd_e                 cmd,
  input  logic [BANK_W-1:0]    ba,
  input  logic                 pre_all,
  output logic [NUM_BANKS-1:0] open_q,
  output logic [NUM_BANKS-1:0] open_next
);
  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
    always_comb begin
      open_next[i] = open_q[i];
      if (accept) begin
        if (cmd == CMD_ACT && ba == BANK_W'(i))
          open_next[i] = 1'b1;
        else if (cmd == CMD_PRE && (pre_all || ba == BANK_W'(i)))
          open_next[i] = 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) open_q[i] <= 1'b0;
      else     open_q[i] <= open_next[i];
    end
  end

  p_pre_all_r9: assert property (@(posedge clk) disable iff (rst)
    (accept && cmd == CMD_PRE && pre_all) |=> (open_q == '0));

  p_act_sets_r3: assert property (@(posedge clk) disable iff (rst)
    (accept && cmd == CMD_ACT) |=> open_q[$past(ba)]);

  p_ignored_r7: assert property (@(posedge clk) disable iff (rst)
    !accept |=> $stable(open_q));
endmodule

// File: rtl/sdram_cmd_frontend.sv
module sdram_cmd_frontend
  import sdram_fe_pkg::*;
#(
  parameter int NUM_BANKS   = 4,
  parameter int ADDR_W      = 11,
  parameter int COL_W       = 8,
  parameter int PRE_ALL_BIT = 10,
  localparam int BANK_W = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cke,
  input  logic                 cs_n,
  input  logic                 ras_n,
  input  logic                 cas_n,
  input  logic                 we_n,
  input  logic [BANK_W-1:0]    ba,
  input  logic [ADDR_W-1:0]    addr,
  output logic                 cmd_valid,
  output logic [2:0]           cmd_code,
  output logic [BANK_W-1:0]    cmd_bank,
  output logic [ADDR_W-1:0]    cmd_row,
  output logic [COL_W-1:0]     cmd_col,
  output logic [NUM_BANKS-1:0] bank_open,
  output logic                 cmd_suspend,
  output logic                 cmd_powerdown,
  output logic                 cmd_err
);
  cmd_e                 cmd;
  logic                 accept;
  logic [NUM_BANKS-1:0] open_next;
  logic                 is_rw, rw_bad, take;

  sdram_cmd_decode u_dec (
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cmd(cmd)
  );

  sdram_bank_tracker #(.NUM_BANKS(NUM_BANKS)) u_banks (
    .clk(clk), .rst(rst), .accept(accept), .cmd(cmd), .ba(ba),
    .pre_all(addr[PRE_ALL_BIT]), .open_q(bank_open), .open_next(open_next)
  );

  sdram_cke_gate u_cke (
    .clk(clk), .rst(rst), .cke(cke), .idle_next(open_next == '0),
    .accept(accept), .suspend_q(cmd_suspend), .powerdown_q(cmd_powerdown)
  );

  assign is_rw  = (cmd == CMD_RD) || (cmd == CMD_WR);
  assign rw_bad = accept && is_rw && !bank_open[ba];
  assign take   = accept && (cmd != CMD_NONE) && !rw_bad;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_valid <= 1'b0;
      cmd_code  <= CMD_NONE;
      cmd_bank  <= '0;
      cmd_row   <= '0;
      cmd_col   <= '0;
      cmd_err   <= 1'b0;
    end else begin
      cmd_valid <= take;
      cmd_code  <= take ? cmd : CMD_NONE;
      cmd_err   <= rw_bad;
      if (take && (cmd == CMD_ACT || is_rw || cmd == CMD_PRE))
        cmd_bank <= ba;
      if (take && cmd == CMD_ACT)
        cmd_row <= addr;
      if (take && is_rw)
        cmd_col <= addr[COL_W-1:0];
    end
  end

  p_deselect_r6: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> !cmd_valid);

  p_err_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    cmd_err |-> (!cmd_valid && $stable(bank_open)));

  p_pd_idle_r10: assert property (@(posedge clk) disable iff (rst)
    cmd_powerdown |-> (bank_open == '0));

  p_frozen_r7: assert property (@(posedge clk) disable iff (rst)
    (!cke && (cmd_suspend || cmd_powerdown)) |=> (!cmd_valid && $stable(bank_open)));
endmodule

// File: tb/sdram_cmd_frontend_test.sv
module sdram_cmd_frontend_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0]  ba = '0;
  logic [10:0] addr = '0;
  logic        cmd_valid, cmd_suspend, cmd_powerdown, cmd_err;
  logic [2:0]  cmd_code;
  logic [1:0]  cmd_bank;
  logic [10:0] cmd_row;
  logic [7:0]  cmd_col;
  logic [3:0]  bank_open;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sdram_cmd_frontend uut (
    .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_bank(cmd_bank),
    .cmd_row(cmd_row), .cmd_col(cmd_col), .bank_open(bank_open),
    .cmd_suspend(cmd_suspend), .cmd_powerdown(cmd_powerdown), .cmd_err(cmd_err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Drive one edge's inputs at a falling edge; outputs are settled at the next falling edge
  task automatic issue(input logic c, input logic [2:0] rcw, input logic [1:0] b,
                       input logic [10:0] a, input logic k);
    cs_n = c; {ras_n, cas_n, we_n} = rcw; ba = b; addr = a; cke = k;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 valid", cmd_valid, 0);
    chk("R1 code", cmd_code, 0);
    chk("R1 fields", {cmd_bank, cmd_row, cmd_col}, 0);
    chk("R1 open", bank_open, 0);
    chk("R1 status", {cmd_suspend, cmd_powerdown, cmd_err}, 0);
  endtask

  task automatic t_activate_rw;
    issue(0, 3'b011, 2'd2, 11'h5A5, 1);
    chk("R2 act valid", cmd_valid, 1);
    chk("R2 act code", cmd_code, 1);
    chk("R3 bank", cmd_bank, 2);
    chk("R3 row", cmd_row, 11'h5A5);
    chk("R3 open", bank_open, 4'b0100);
    issue(0, 3'b101, 2'd2, 11'h73C, 1);
    chk("R2 rd code", cmd_code, 2);
    chk("R4 col", cmd_col, 8'h3C);
    chk("R4 row held", cmd_row, 11'h5A5);
    issue(0, 3'b100, 2'd2, 11'h011, 1);
    chk("R2 wr code", cmd_code, 3);
    chk("R4 wr col", cmd_col, 8'h11);
    chk("R2 one-cycle strobe", cmd_valid, 1);
    issue(1, 3'b111, 2'd0, 11'h0, 1);
    chk("R2 strobe drops", cmd_valid, 0);
  endtask

  task automatic t_closed_bank;
    issue(0, 3'b101, 2'd0, 11'h0FF, 1);
    chk("R5 err", cmd_err, 1);
    chk("R5 no valid", cmd_valid, 0);
    chk("R5 col held", cmd_col, 8'h11);
    chk("R5 bank held", cmd_bank, 2);
    chk("R5 open held", bank_open, 4'b0100);
    issue(1, 3'b111, 2'd0, 11'h0, 1);
    chk("R5 err pulse ends", cmd_err, 0);
  endtask

  task automatic t_deselect_nop;
    issue(1, 3'b011, 2'd1, 11'h123, 1);
    chk("R6 deselect valid", cmd_valid, 0);
    chk("R6 deselect open", bank_open, 4'b0100);
    chk("R6 deselect row", cmd_row, 11'h5A5);
    issue(0, 3'b111, 2'd3, 11'h7FF, 1);
    chk("R6 nop valid", cmd_valid, 0);
    chk("R6 nop open", bank_open, 4'b0100);
  endtask

  task automatic t_suspend;
    issue(0, 3'b011, 2'd1, 11'h0AA, 0);   // entry edge still executes
    chk("R7 entry accepted", cmd_valid, 1);
    chk("R7 entry open", bank_open, 4'b0110);
    chk("R7 suspend", cmd_suspend, 1);
    chk("R10 no pd", cmd_powerdown, 0);
    issue(0, 3'b011, 2'd3, 11'h0BB, 0);   // ignored
    chk("R7 ignored valid", cmd_valid, 0);
    chk("R7 ignored open", bank_open, 4'b0110);
    chk("R7 ignored row", cmd_row, 11'h0AA);
    chk("R7 suspend held", cmd_suspend, 1);
    issue(0, 3'b010, 2'd1, 11'h000, 1);   // exit edge precharges bank 1
    chk("R8 exit accepted", cmd_code, 4);
    chk("R8 exit open", bank_open, 4'b0100);
    chk("R8 suspend clear", cmd_suspend, 0);
  endtask

  task automatic t_precharge_all;
    issue(0, 3'b011, 2'd0, 11'h001, 1);
    chk("R9 setup open", bank_open, 4'b0101);
    issue(0, 3'b010, 2'd3, 11'h000, 1);
    chk("R9 single pre no effect on others", bank_open, 4'b0101);
    issue(0, 3'b010, 2'd3, 11'h400, 1);
    chk("R9 pre all", bank_open, 4'b0000);
  endtask

  task automatic t_powerdown;
    issue(0, 3'b111, 2'd0, 11'h0, 0);
    chk("R10 pd", cmd_powerdown, 1);
    chk("R10 no suspend", cmd_suspend, 0);
    issue(0, 3'b011, 2'd2, 11'h222, 0);
    chk("R10 pd ignored open", bank_open, 0);
    chk("R10 pd held", cmd_powerdown, 1);
    issue(0, 3'b011, 2'd0, 11'h333, 1);
    chk("R8 pd exit accepted", bank_open, 4'b0001);
    chk("R8 pd clear", cmd_powerdown, 0);
    chk("R8 exit row", cmd_row, 11'h333);
  endtask

  task automatic t_ref_mrs;
    issue(0, 3'b001, 2'd3, 11'h7FF, 1);
    chk("R11 ref code", cmd_code, 5);
    chk("R11 ref fields", {cmd_bank, cmd_row}, {2'd0, 11'h333});
    issue(0, 3'b000, 2'd2, 11'h4CC, 1);
    chk("R11 mrs code", cmd_code, 6);
    chk("R11 mrs fields", {cmd_bank, cmd_row, cmd_col}, {2'd0, 11'h333, 8'h11});
    chk("R11 open held", bank_open, 4'b0001);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset;
    t_activate_rw;
    t_closed_bank;
    t_deselect_nop;
    t_suspend;
    t_precharge_all;
    t_powerdown;
    t_ref_mrs;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #40000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule